// File: doc/BRIEF.md
# Management Slave Host Register Bank

This block is the host-facing register set that sits beside the frame engine of a two-wire serial management slave. The host programs a control word: enable, the slave's port address, a switch that turns off the preamble check, and three interrupt enables. It reads back what the serial master has written and supplies the values the master will read. The frame engine, which is outside this block, sends strobes into the bank:
- a completed write frame, which stores 16 bits into input register x;
- a read capture, which takes a copy of output register x;
- error events for preamble, start and turnaround faults.

The bank keeps one write flag and one read flag per register and three error status bits. The host clears each of these by writing a 1 to it. A single interrupt line combines all of these sources.

The host port is synchronous and word addressed by byte offset. Writes are single-cycle strobes. Read data is combinational from the offset. The control fields go out to the frame engine as plain outputs, and the captured read word is held in a register.

Top module: `mgmt_regbank`

## Requirements
- R1: The control word at offset 0x000 reads back as: enable bit 0, write-interrupt enable bit 1, read-interrupt enable bit 2, error-interrupt enable bit 3, preamble-check disable bit 7, port address bits 12:8. All other bits read 0, and everything resets to 0.
- R2: While enable is 1, a control write changes only the enable and the three interrupt enables. Port address and preamble-check disable keep their values. They do change while enable is 0, including in the write that sets enable.
- R3: When enable is 1, a frame-engine write strobe stores its 16-bit data into input register x. The host reads that register at 0x100+4x, bits 15:0. While enable is 0, the strobe changes nothing.
- R4: The write-flag vector (0x004) and read-flag vector (0x00C) set bit x on an engine write strobe or read capture of register x while enabled. A bit clears only when the host writes 1 to that bit at 0x008 or 0x010. If a set and a clear of the same bit fall in one cycle, the set wins.
- R5: Engine error events set status bits at 0x014: preamble bit 0, start bit 1, turnaround bit 2. Writing 1 to the matching bit at 0x018 clears a status bit. Offset 0x018 always reads 0, and host writes to 0x014 have no effect.
- R6: `irq` is 1 exactly while at least one of these holds: any write flag is set with write-interrupt enable, any read flag is set with read-interrupt enable, or any status bit is set with error-interrupt enable.
- R7: Output register x at 0x180+4x, bits 15:0, is host read/write. On a read capture of x while enabled, `fe_rd_data` takes the register's value in the next cycle.
- R8: A host write to output register x is discarded when it falls in the same cycle as a read capture of x. A write to a different output register in that cycle is kept.
- R9: A control write with bit 0 at 0 zeroes all input registers. The write flags, read flags and status bits keep their values.
- R10: Reserved or unaligned offsets read as 0. Host writes to the flag vectors, the status word, the input registers or reserved offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wen | input | 1 | Host write strobe |
| h_addr | input | 9 | Host byte offset |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for h_addr |
| fe_wr_stb | input | 1 | Engine: write frame completed |
| fe_wr_idx | input | 5 | Engine: register written |
| fe_wr_data | input | 16 | Engine: data written |
| fe_rd_stb | input | 1 | Engine: read capture |
| fe_rd_idx | input | 5 | Engine: register captured |
| fe_err | input | 3 | Engine error events {turnaround, start, preamble} |
| fe_rd_data | output | 16 | Captured output-register value |
| cfg_en | output | 1 | Enable |
| cfg_port | output | 5 | Port address |
| cfg_nopre | output | 1 | Preamble-check disable |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest condition to reach is a cycle in which two agents touch the same bit or word at once. One case is a host write to output register x colliding with a capture of x. The other is a host clear of a flag bit landing on the cycle that sets it. The bench has a single-cycle task that drives the host strobe and the engine strobes together on one falling edge. It then checks the captured word, the read-back register and the flag vector, and repeats with a different register index to show that a non-colliding write survives.

// File: rtl/mgmt_regbank.sv
module mgmt_regbank #(
  parameter int NREG = 32,
  parameter int DW   = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_wen,
  input  logic [8:0]    h_addr,
  input  logic [31:0]   h_wdata,
  output logic [31:0]   h_rdata,
  input  logic          fe_wr_stb,
  input  logic [IW-1:0] fe_wr_idx,
  input  logic [DW-1:0] fe_wr_data,
  input  logic          fe_rd_stb,
  input  logic [IW-1:0] fe_rd_idx,
  input  logic [2:0]    fe_err,
  output logic [DW-1:0] fe_rd_data,
  output logic          cfg_en,
  output logic [4:0]    cfg_port,
  output logic          cfg_nopre,
  output logic          irq
);
  logic en, wrie, rdie, eie, nopre;
  logic [4:0] port;
  logic [DW-1:0] din  [NREG];
  logic [DW-1:0] dout [NREG];
  logic [NREG-1:0] wrf, rdf;
  logic [2:0] err;

  wire          aligned = (h_addr[1:0] == 2'b00);
  wire [6:0]    wa      = h_addr[8:2];
  wire [IW-1:0] ridx    = h_addr[IW+1:2];
  wire          din_sel  = aligned && (h_addr[8:7] == 2'b10);
  wire          dout_sel = aligned && (h_addr[8:7] == 2'b11);
  wire ctrl_w = h_wen && aligned && (wa == 7'd0);
  wire wclr_w = h_wen && aligned && (wa == 7'd2);
  wire rclr_w = h_wen && aligned && (wa == 7'd4);
  wire eclr_w = h_wen && aligned && (wa == 7'd6);
  wire wr_hit = en && fe_wr_stb;
  wire rd_hit = en && fe_rd_stb;
  wire [NREG-1:0] wset = wr_hit ? (NREG'(1) << fe_wr_idx) : '0;
  wire [NREG-1:0] rset = rd_hit ? (NREG'(1) << fe_rd_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {en, wrie, rdie, eie, nopre} <= '0;
      port <= '0;
    end else if (ctrl_w) begin
      en   <= h_wdata[0];
      wrie <= h_wdata[1];
      rdie <= h_wdata[2];
      eie  <= h_wdata[3];
      if (!en) begin
        nopre <= h_wdata[7];
        port  <= h_wdata[12:8];
      end
    end
  end

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n || (ctrl_w && !h_wdata[0]))
          din[i] <= '0;
        else if (wr_hit && fe_wr_idx == IW'(i))
          din[i] <= fe_wr_data;
      end
      always_ff @(posedge clk) begin
        if (!rst_n)
          dout[i] <= '0;
        else if (h_wen && dout_sel && ridx == IW'(i) &&
                 !(rd_hit && fe_rd_idx == IW'(i)))
          dout[i] <= h_wdata[DW-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrf <= '0;
      rdf <= '0;
      err <= '0;
      fe_rd_data <= '0;
    end else begin
      wrf <= (wrf & ~(wclr_w ? h_wdata[NREG-1:0] : '0)) | wset;
      rdf <= (rdf & ~(rclr_w ? h_wdata[NREG-1:0] : '0)) | rset;
      err <= (err & ~(eclr_w ? h_wdata[2:0] : 3'b0)) | (en ? fe_err : 3'b0);
      if (rd_hit) fe_rd_data <= dout[fe_rd_idx];
    end
  end

  always_comb begin
    h_rdata = '0;
    if (din_sel)       h_rdata[DW-1:0] = din[ridx];
    else if (dout_sel) h_rdata[DW-1:0] = dout[ridx];
    else if (aligned && h_addr[8:7] == 2'b00) begin
      case (h_addr[6:2])
        5'd0: h_rdata = {19'b0, port, nopre, 3'b0, eie, rdie, wrie, en};
        5'd1: h_rdata[NREG-1:0] = wrf;
        5'd3: h_rdata[NREG-1:0] = rdf;
        5'd5: h_rdata[2:0] = err;
        default: h_rdata = '0;
      endcase
    end
  end

  assign cfg_en    = en;
  assign cfg_port  = port;
  assign cfg_nopre = nopre;
  assign irq = (wrie && |wrf) || (rdie && |rdf) || (eie && |err);
endmodule

module mgmt_regbank_chk #(
  parameter int NREG = 32,
  parameter int DW   = 16,
  localparam int IW  = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_wen,
  input logic [8:0]    h_addr,
  input logic [31:0]   h_wdata,
  input logic [31:0]   h_rdata,
  input logic          fe_wr_stb,
  input logic [IW-1:0] fe_wr_idx,
  input logic          fe_rd_stb,
  input logic [IW-1:0] fe_rd_idx,
  input logic [DW-1:0] fe_rd_data,
  input logic          cfg_en,
  input logic [4:0]    cfg_port,
  input logic          cfg_nopre,
  input logic          irq,
  input logic [NREG-1:0] wrf,
  input logic [NREG-1:0] rdf,
  input logic [2:0]    err
);
  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wen && h_addr == 9'h000 && cfg_en) |=> ($stable(cfg_port) && $stable(cfg_nopre))); // R2

  AST_WRF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_wr_stb && cfg_en) |=> wrf[$past(fe_wr_idx)]); // R4

  AST_RDF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_rd_stb && cfg_en) |=> rdf[$past(fe_rd_idx)]); // R4

  AST_WRF_CLR_ONLY_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(wrf) & ~wrf)) |-> $past(h_wen && h_addr == 9'h008)); // R4

  AST_ERR_CLR_ONLY_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(err) & ~err)) |-> $past(h_wen && h_addr == 9'h018)); // R5

  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wrf == '0 && rdf == '0 && err == 3'b0) |-> !irq); // R6

  AST_COLLIDE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_rd_stb && cfg_en && h_wen && h_addr[8:7] == 2'b11 && h_addr[1:0] == 2'b00 &&
     h_addr[IW+1:2] == fe_rd_idx) |=> (fe_rd_data == $past(h_rdata[DW-1:0]))); // R8
endmodule

bind mgmt_regbank mgmt_regbank_chk #(.NREG(NREG), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_wen(h_wen), .h_addr(h_addr), .h_wdata(h_wdata),
  .h_rdata(h_rdata), .fe_wr_stb(fe_wr_stb), .fe_wr_idx(fe_wr_idx),
  .fe_rd_stb(fe_rd_stb), .fe_rd_idx(fe_rd_idx), .fe_rd_data(fe_rd_data),
  .cfg_en(cfg_en), .cfg_port(cfg_port), .cfg_nopre(cfg_nopre), .irq(irq),
  .wrf(wrf), .rdf(rdf), .err(err)
);

// File: tb/tb_mgmt_regbank.sv
module tb_mgmt_regbank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_wen = 1'b0;
  logic [8:0] h_addr = '0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic fe_wr_stb = 1'b0;
  logic [4:0] fe_wr_idx = '0;
  logic [15:0] fe_wr_data = '0;
  logic fe_rd_stb = 1'b0;
  logic [4:0] fe_rd_idx = '0;
  logic [2:0] fe_err = '0;
  logic [15:0] fe_rd_data;
  logic cfg_en, cfg_nopre, irq;
  logic [4:0] cfg_port;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  mgmt_regbank dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic wen, input logic [8:0] a, input logic [31:0] d,
                     input logic fw, input logic [4:0] wi, input logic [15:0] wd,
                     input logic fr, input logic [4:0] ri, input logic [2:0] fe);
    @(negedge clk);
    h_wen = wen; h_addr = a; h_wdata = d;
    fe_wr_stb = fw; fe_wr_idx = wi; fe_wr_data = wd;
    fe_rd_stb = fr; fe_rd_idx = ri; fe_err = fe;
    @(negedge clk);
    h_wen = 0; fe_wr_stb = 0; fe_rd_stb = 0; fe_err = 0;
  endtask

  task automatic hw(input logic [8:0] a, input logic [31:0] d);
    cyc(1, a, d, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rdchk(input string req, input logic [8:0] a, input logic [31:0] exp);
    @(negedge clk);
    h_addr = a;
    #2 chk(req, h_rdata, exp);
  endtask

  task automatic t_reset;
    rdchk("R1 reset ctrl", 9'h000, 0);
    rdchk("R4 reset wrf", 9'h004, 0);
    rdchk("R5 reset status", 9'h014, 0);
    chk("R6 reset irq", {31'b0, irq}, 0);
  endtask

  task automatic t_ctrl;
    hw(9'h000, 32'h0000_0583);
    rdchk("R1 ctrl layout", 9'h000, 32'h583);
    chk("R1 cfg_port", {27'b0, cfg_port}, 5);
    hw(9'h000, 32'h0000_1F0F);
    rdchk("R2 locked fields", 9'h000, 32'h58F);
  endtask

  task automatic t_fewrite;
    cyc(0, 0, 0, 1, 3, 16'hBEEF, 0, 0, 0);
    rdchk("R3 din3", 9'h10C, 32'hBEEF);
    rdchk("R3 din0 untouched", 9'h100, 0);
    rdchk("R4 wrf bit3", 9'h004, 32'h8);
    chk("R6 irq write", {31'b0, irq}, 1);
    hw(9'h008, 32'h8);
    rdchk("R4 wrf cleared", 9'h004, 0);
    chk("R6 irq cleared", {31'b0, irq}, 0);
    cyc(1, 9'h008, 32'h80, 1, 7, 16'h1234, 0, 0, 0);
    rdchk("R4 set wins", 9'h004, 32'h80);
    hw(9'h008, 32'h80);
  endtask

  task automatic t_ro;
    hw(9'h004, 32'hFFFF_FFFF);
    rdchk("R10 wrf not writable", 9'h004, 0);
    hw(9'h10C, 32'h0);
    rdchk("R10 din not writable", 9'h10C, 32'hBEEF);
    rdchk("R10 reserved", 9'h020, 0);
    rdchk("R10 unaligned", 9'h10D, 0);
  endtask

  task automatic t_err;
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 3'b010);
    rdchk("R5 start err", 9'h014, 32'h2);
    chk("R6 irq err", {31'b0, irq}, 1);
    hw(9'h014, 32'h7);
    rdchk("R5 status write ignored", 9'h014, 32'h2);
    rdchk("R5 clear reg reads 0", 9'h018, 0);
    hw(9'h018, 32'h2);
    rdchk("R5 cleared", 9'h014, 0);
    chk("R6 irq after err clr", {31'b0, irq}, 0);
  endtask

  task automatic t_dout;
    hw(9'h1A4, 32'hA5A5);
    rdchk("R7 dout9 rw", 9'h1A4, 32'hA5A5);
    cyc(0, 0, 0, 0, 0, 0, 1, 9, 0);
    chk("R7 capture", {16'b0, fe_rd_data}, 32'hA5A5);
    rdchk("R4 rdf bit9", 9'h00C, 32'h200);
    chk("R6 irq read", {31'b0, irq}, 1);
    hw(9'h010, 32'h200);
    rdchk("R4 rdf cleared", 9'h00C, 0);
  endtask

  task automatic t_collide;
    cyc(1, 9'h1A4, 32'h1111, 0, 0, 0, 1, 9, 0);
    chk("R8 capture old", {16'b0, fe_rd_data}, 32'hA5A5);
    rdchk("R8 write dropped", 9'h1A4, 32'hA5A5);
    cyc(1, 9'h1A8, 32'h2222, 0, 0, 0, 1, 9, 0);
    rdchk("R8 other reg kept", 9'h1A8, 32'h2222);
    hw(9'h010, 32'h200);
  endtask

  task automatic t_disable;
    cyc(0, 0, 0, 1, 4, 16'h4444, 0, 0, 0);
    hw(9'h000, 32'h0);
    rdchk("R9 din3 cleared", 9'h10C, 0);
    rdchk("R9 din4 cleared", 9'h110, 0);
    rdchk("R9 wrf kept", 9'h004, 32'h10);
    cyc(0, 0, 0, 1, 5, 16'h5555, 0, 0, 0);
    rdchk("R3 disabled din5", 9'h114, 0);
    rdchk("R3 disabled wrf", 9'h004, 32'h10);
    hw(9'h000, 32'h0A00);
    rdchk("R2 unlocked", 9'h000, 32'hA00);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_ctrl;
    t_fewrite;
    t_ro;
    t_err;
    t_dout;
    t_collide;
    t_disable;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule